// File: doc/BRIEF.md
# Per-Channel Zero-Run Auto Mute

This block sits in the sample-clock domain of a stereo audio path and silences a channel that has gone quiet. Each frame arrives as one signed 24-bit left sample and one signed 24-bit right sample, marked by a single valid strobe. For each channel the block counts how many exactly-zero samples have arrived in a row. When that run reaches the threshold (2048 samples by default), the channel's mute flag rises and its outgoing sample is forced to zero.

The two channels are independent, so one can be muted while the other keeps playing. The count is kept in valid frames, not in clock cycles. The threshold therefore means the same thing at any input sample rate and for any spacing of the strobes. A single enable input turns the whole function on or off. Outputs are registered: a frame presented with `in_valid` in one cycle appears on the outputs, with its mute decision, in the next cycle.

Top module: `zero_run_mute`

## Requirements
- R1: A synchronous active-high `rst` clears both run counters. In the cycle after reset, `mute_left`, `mute_right`, `out_valid`, `out_left` and `out_right` all read 0.
- R2: With `en` high, a channel's mute flag is 1 in the cycle after the THRESH-th (default 2048) consecutive valid frame whose sample on that channel equals 0. After THRESH-1 such frames, the flag is still 0.
- R3: The two channels count and mute independently. A zero run on one channel never sets or clears the other channel's flag.
- R4: While `en` is low, no run is counted. A low `en` clears both counters and both flags in the next clock cycle, whether or not a frame is valid in that cycle. Valid samples pass to the outputs unchanged.
- R5: The run counter saturates at THRESH. Any number of further zero samples keeps the channel muted and never wraps the counter.
- R6: A valid frame with a non-zero sample on a channel, negative values such as 0x800000 included, clears that channel's run and drops its mute flag. That same sample appears on the channel's output in the next cycle.
- R7: Whenever a channel's mute flag is 1, that channel's output sample is 0.
- R8: `out_valid` equals `in_valid` delayed by one cycle. Cycles without `in_valid` change neither the counters nor the output samples.
- R9: The threshold counts valid frames only. Idle cycles between strobes neither lengthen nor shorten the run needed to mute.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample-domain clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Enables zero-run detection |
| in_valid | input | 1 | Frame strobe for in_left/in_right |
| in_left | input | 24 | Left sample, two's complement |
| in_right | input | 24 | Right sample, two's complement |
| out_valid | output | 1 | Strobe for the registered output frame |
| out_left | output | 24 | Left sample after gating |
| out_right | output | 24 | Right sample after gating |
| mute_left | output | 1 | Left channel is muted |
| mute_right | output | 1 | Right channel is muted |

## Verification
The bound checker enforces several rules on every cycle. It checks that a muted output is zero and that the strobe is delayed by one cycle. It checks that a flag can only rise after a valid zero sample with the enable high, that a non-zero sample or a low enable releases the flag, and that the counter never exceeds the threshold. Other behaviour can only be shown by the bench's scenarios, which the cycle-by-cycle model follows:
- the exact count at which the flag rises, and that it does not rise one sample earlier;
- independence of the channels under mixed traffic;
- a run broken one sample short of the threshold;
- saturation over long silences;
- strobes spaced by idle cycles.

// File: rtl/zero_run_mute.sv
module zero_run_mute #(
  parameter int W      = 24,
  parameter int THRESH = 2048
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         in_valid,
  input  logic [W-1:0] in_left,
  input  logic [W-1:0] in_right,
  output logic         out_valid,
  output logic [W-1:0] out_left,
  output logic [W-1:0] out_right,
  output logic         mute_left,
  output logic         mute_right
);
  localparam int CW = $clog2(THRESH + 1);
  localparam logic [CW-1:0] LIMIT = CW'(THRESH);

  logic [W-1:0]  din  [2];
  logic [W-1:0]  dout [2];
  logic [1:0]    mute;
  logic [CW-1:0] cnt  [2];

  assign din[0] = in_left;
  assign din[1] = in_right;
  assign out_left   = dout[0];
  assign out_right  = dout[1];
  assign mute_left  = mute[0];
  assign mute_right = mute[1];

  for (genvar c = 0; c < 2; c++) begin : g_ch
    logic [CW-1:0] cnt_nx;
    logic          mute_nx;

    always_comb begin
      if (!en)                cnt_nx = '0;
      else if (!in_valid)     cnt_nx = cnt[c];
      else if (din[c] != '0)  cnt_nx = '0;
      else if (cnt[c] == LIMIT) cnt_nx = cnt[c];
      else                    cnt_nx = cnt[c] + 1'b1;
    end

    assign mute_nx = (cnt_nx == LIMIT);

    always_ff @(posedge clk) begin
      if (rst) begin
        cnt[c]  <= '0;
        mute[c] <= 1'b0;
        dout[c] <= '0;
      end else begin
        cnt[c]  <= cnt_nx;
        mute[c] <= mute_nx;
        if (in_valid) dout[c] <= mute_nx ? '0 : din[c];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= in_valid;
  end
endmodule

// File: rtl/zero_run_mute_chk.sv
module zero_run_mute_chk #(
  parameter int W      = 24,
  parameter int THRESH = 2048
) (
  input logic         clk,
  input logic         rst,
  input logic         en,
  input logic         in_valid,
  input logic [W-1:0] in_left,
  input logic [W-1:0] in_right,
  input logic         out_valid,
  input logic [W-1:0] out_left,
  input logic [W-1:0] out_right,
  input logic         mute_left,
  input logic         mute_right,
  input logic [$clog2(THRESH+1)-1:0] cnt_l,
  input logic [$clog2(THRESH+1)-1:0] cnt_r
);
  assert_muted_left_zero_R7: assert property (@(posedge clk) disable iff (rst)
    mute_left |-> out_left == '0);
  assert_muted_right_zero_R7: assert property (@(posedge clk) disable iff (rst)
    mute_right |-> out_right == '0);

  assert_valid_delay_R8: assert property (@(posedge clk) disable iff (rst)
    ##1 out_valid == $past(in_valid));

  assert_rise_needs_zero_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(mute_left) |-> $past(en && in_valid && in_left == '0));
  assert_rise_needs_zero_right_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(mute_right) |-> $past(en && in_valid && in_right == '0));

  assert_disable_clears_R4: assert property (@(posedge clk) disable iff (rst)
    !en |=> !mute_left && !mute_right);

  assert_nonzero_release_R6: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_left != '0 |=> !mute_left && out_left == $past(in_left));
  assert_nonzero_release_right_R6: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_right != '0 |=> !mute_right && out_right == $past(in_right));

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
    cnt_l <= THRESH && cnt_r <= THRESH);

  assert_idle_holds_R8: assert property (@(posedge clk) disable iff (rst)
    en && !in_valid |=> $stable(mute_left) && $stable(mute_right)
                        && $stable(out_left) && $stable(out_right));
endmodule

bind zero_run_mute zero_run_mute_chk #(.W(W), .THRESH(THRESH)) u_chk (
  .clk(clk), .rst(rst), .en(en), .in_valid(in_valid),
  .in_left(in_left), .in_right(in_right), .out_valid(out_valid),
  .out_left(out_left), .out_right(out_right),
  .mute_left(mute_left), .mute_right(mute_right),
  .cnt_l(cnt[0]), .cnt_r(cnt[1])
);

// File: tb/tb_zero_run_mute.sv
module tb_zero_run_mute;
  localparam int W = 24;
  localparam int TH = 2048;

  logic clk = 0, rst = 1, en = 0, in_valid = 0;
  logic [W-1:0] in_left = '0, in_right = '0;
  logic out_valid, mute_left, mute_right;
  logic [W-1:0] out_left, out_right;

  always #2.5 clk = ~clk;

  zero_run_mute #(.W(W), .THRESH(TH)) dut (
    .clk(clk), .rst(rst), .en(en), .in_valid(in_valid),
    .in_left(in_left), .in_right(in_right), .out_valid(out_valid),
    .out_left(out_left), .out_right(out_right),
    .mute_left(mute_left), .mute_right(mute_right));

  int checks = 0, errors = 0;
  bit done = 0;

  // behavioural reference model
  int run_l = 0, run_r = 0;
  bit em_l = 0, em_r = 0, ev = 0;
  logic [W-1:0] eo_l = '0, eo_r = '0;

  always @(posedge clk) begin
    if (rst) begin
      run_l = 0; run_r = 0; em_l = 0; em_r = 0; ev = 0; eo_l = '0; eo_r = '0;
    end else begin
      ev = in_valid;
      if (!en) begin
        run_l = 0; run_r = 0;
      end else if (in_valid) begin
        run_l = (in_left  == 0) ? ((run_l < TH) ? run_l + 1 : TH) : 0;
        run_r = (in_right == 0) ? ((run_r < TH) ? run_r + 1 : TH) : 0;
      end
      em_l = (run_l >= TH);
      em_r = (run_r >= TH);
      if (in_valid) begin
        eo_l = em_l ? '0 : in_left;
        eo_r = em_r ? '0 : in_right;
      end
    end
  end

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // every-cycle comparison against the model (R7, R8)
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R8 out_valid", W'(out_valid), W'(ev));
      chk("R2 mute_left", W'(mute_left), W'(em_l));
      chk("R3 mute_right", W'(mute_right), W'(em_r));
      chk("R7 out_left", out_left, eo_l);
      chk("R7 out_right", out_right, eo_r);
    end
  end

  task automatic frame(logic [W-1:0] l, logic [W-1:0] r, int gap);
    in_left = l; in_right = r; in_valid = 1;
    @(negedge clk);
    in_valid = 0;
    for (int g = 0; g < gap; g++) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 mute_left", W'(mute_left), 0);
    chk("R1 mute_right", W'(mute_right), 0);
    chk("R1 out_valid", W'(out_valid), 0);
    chk("R1 out_left", out_left, 0);

    en = 1;
    for (int i = 0; i < TH - 1; i++) frame(0, W'(i + 1), 0);
    chk("R2 not yet muted", W'(mute_left), 0);
    frame(0, 24'h000777, 0);
    chk("R2 muted at threshold", W'(mute_left), 1);
    chk("R3 right unaffected", W'(mute_right), 0);
    chk("R3 right passes", out_right, 24'h000777);

    for (int i = 0; i < TH; i++) frame(0, 0, 3);
    chk("R9 right muted with gaps", W'(mute_right), 1);
    chk("R5 left still muted", W'(mute_left), 1);
    repeat (10) @(negedge clk);
    chk("R8 idle keeps mute", W'(mute_right), 1);

    for (int i = 0; i < 3000; i++) frame(0, 0, 0);
    chk("R5 saturated left", W'(mute_left), 1);
    chk("R5 saturated right", W'(mute_right), 1);

    frame(24'h123456, 0, 0);
    chk("R6 release left", W'(mute_left), 0);
    chk("R6 sample passes", out_left, 24'h123456);
    chk("R7 right output zero", out_right, 0);
    chk("R3 right stays muted", W'(mute_right), 1);

    en = 0;
    @(negedge clk);
    chk("R4 disable clears right", W'(mute_right), 0);
    for (int i = 0; i < TH + 100; i++) frame(0, 0, 0);
    chk("R4 no count while disabled", W'(mute_left), 0);
    chk("R4 no count while disabled right", W'(mute_right), 0);

    en = 1;
    for (int i = 0; i < TH - 1; i++) frame(0, 0, 0);
    frame(24'h800000, 0, 0);
    chk("R6 negative sample releases run", W'(mute_left), 0);
    chk("R6 negative sample passes", out_left, 24'h800000);
    chk("R2 right reaches threshold", W'(mute_right), 1);
    for (int i = 0; i < TH - 1; i++) frame(0, 24'h000001, 1);
    chk("R6 run restarted", W'(mute_left), 0);
    frame(0, 24'h000001, 0);
    chk("R2 muted after fresh run", W'(mute_left), 1);
    chk("R6 right released", W'(mute_right), 0);

    rst = 1;
    @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 reset clears mute", W'(mute_left), 0);
    finish_run();
  end
endmodule